// File: doc/BRIEF.md
# Translation Table Update Command Engine

This block carries out maintenance commands against an external table of 64-bit address translation entries. Four commands exist: store one entry, fetch one entry, fill a run of consecutive pages with a single value, and store a run of pages whose entries are read from a list held in system memory. Each command supplies an opcode, a bus address, a value (or the list address), and a page count. The engine ends every command with a one-cycle completion pulse that carries a success or parameter-error status and, for the fetch command, the stored entry.

The table is reached through a plain write/read port whose read data arrives one cycle after the read strobe. List words are fetched through a request/response port: the request is held until it is accepted, and one response comes back for each accepted request. Every entry store is echoed, one cycle later, as an update strobe. The strobe carries the page-aligned bus address, the translated page, the in-page offset mask and the two permission bits, so that translation caches can be kept coherent.

The controller is a state machine with these states:

- `ST_IDLE` waits for a command. It moves to `ST_WRITE`, `ST_READ_ISSUE` or `ST_FETCH_REQ` on acceptance, and goes straight to `ST_DONE` on an argument error or a zero page count.
- `ST_WRITE` checks the bounds of the current page and stores the entry. It goes to `ST_DONE` after the last page or on a bounds failure. Otherwise it loops to `ST_WRITE` for a fill, or goes to `ST_FETCH_REQ` for a list.
- `ST_FETCH_REQ` presents a list-word request and goes to `ST_FETCH_WAIT` once it is accepted.
- `ST_FETCH_WAIT` waits for the response and then goes to `ST_WRITE`.
- `ST_READ_ISSUE` goes to `ST_READ_WAIT` when the index is in range, and to `ST_DONE` when it is not.
- `ST_READ_WAIT` captures the read data and goes to `ST_DONE`.
- `ST_DONE` pulses completion and returns to `ST_IDLE`.

Top module: `tce_update_engine`

## Requirements
- R1: Opcode 0 (store one) writes `cmd_val` at index ((page-aligned `cmd_addr`) − BASE) >> PAGE_SHIFT. An index at or above DEPTH, including one produced by an address below BASE, returns error (`done_err`=1) and writes nothing.
- R2: Store-one and fetch-one ignore the low PAGE_SHIFT bits of `cmd_addr`: the address is aligned down to its page before the index is formed.
- R3: Opcode 1 (fetch one) returns the stored entry on `done_data` with `done_err`=0, or `done_err`=1 with `done_data`=0 when the index is out of range. For every other command `done_data` is 0.
- R4: Opcode 2 (fill) with a count above DEPTH returns error and writes nothing. Otherwise it writes `cmd_val` to page k = 0..count−1 at the aligned address plus k·2^PAGE_SHIFT.
- R5: Opcode 3 (list) with a count above MAX_LIST (512), or with a list address whose low 12 bits are not all zero, returns error, fetches nothing and writes nothing.
- R6: List entry k is the 64-bit word fetched from (list address with bits 1:0 cleared) + 8·k. It is written to page k of the run, and every request address is 8-byte aligned and held stable until it is accepted.
- R7: Fill and list stop at the first page whose index is out of range and return error. Pages written before that point keep their new values, and no later page is written.
- R8: One cycle after each table write, `upd_valid` pulses. `upd_iova` is the page-aligned bus address, `upd_page` is the entry with its low PAGE_SHIFT bits cleared, `upd_mask` is 2^PAGE_SHIFT−1 and `upd_perm` is entry bits 1:0. `upd_valid` is low at all other times.
- R9: Opcodes 4 to 7 return error and write nothing.
- R10: A command is taken when `cmd_valid` is high and `busy` is low. `busy` stays high from the next cycle through the cycle in which `done` pulses. `done` lasts exactly one cycle, and `busy` is low in the cycle after it.
- R11: Fill or list with a count of zero completes one cycle after acceptance, with success and no writes.
- R12: After reset, `busy`, `done`, `tbl_we`, `tbl_re`, `mem_req_valid` and `upd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 0 store, 1 fetch, 2 fill, 3 list |
| cmd_addr | input | AW | Bus address of the first page |
| cmd_val | input | EW | Entry value, or list address for opcode 3 |
| cmd_cnt | input | CNT_W | Page count for fill and list |
| busy | output | 1 | Command in progress; new commands blocked |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Parameter error, valid with done |
| done_data | output | EW | Fetched entry, valid with done |
| tbl_we | output | 1 | Table write strobe |
| tbl_re | output | 1 | Table read strobe (data next cycle) |
| tbl_idx | output | IDX_W | Table index |
| tbl_wdata | output | EW | Table write data |
| tbl_rdata | input | EW | Table read data |
| mem_req_valid | output | 1 | List word read request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_addr | output | MAW | List word byte address |
| mem_rsp_valid | input | 1 | List word response present |
| mem_rsp_data | input | EW | List word |
| upd_valid | output | 1 | Entry update strobe |
| upd_iova | output | AW | Page-aligned bus address of updated entry |
| upd_page | output | EW | Translated page of updated entry |
| upd_mask | output | EW | In-page offset mask |
| upd_perm | output | 2 | Permission bits of updated entry |

## Verification
The assertions assume three things about the inputs: `mem_rsp_valid` arrives only for a request that has been accepted, exactly once, and while the engine is waiting for it; and `tbl_rdata` belongs to the read strobed in the cycle before. The bench memory model answers each accepted request exactly one cycle later and never otherwise. It varies `mem_req_ready` at random to exercise held requests. Its table model registers read data, so the inputs never leave these assumptions, even when random commands run off the end of the table or use bad list arguments.

// File: rtl/tce_cmd_pkg.sv
package tce_cmd_pkg;

    localparam logic [2:0] OP_STORE = 3'd0;
    localparam logic [2:0] OP_FETCH = 3'd1;
    localparam logic [2:0] OP_FILL  = 3'd2;
    localparam logic [2:0] OP_LIST  = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_READ_ISSUE,
        ST_READ_WAIT,
        ST_DONE
    } eng_state_t;

endpackage

// File: rtl/tce_idx_check.sv
module tce_idx_check #(
    parameter int              AW         = 32,
    parameter int              DEPTH      = 64,
    parameter int              PAGE_SHIFT = 12,
    parameter logic [AW-1:0]   BASE       = 32'h0010_0000,
    localparam int             IDX_W      = $clog2(DEPTH)
) (
    input  logic [AW-1:0]    addr,
    output logic [IDX_W-1:0] idx,
    output logic             in_range
);
    logic [AW-1:0] offset;
    logic [AW-1:0] page_no;

    always_comb begin
        offset   = addr - BASE;
        page_no  = offset >> PAGE_SHIFT;
        in_range = (page_no < AW'(DEPTH));
        idx      = page_no[IDX_W-1:0];
    end
endmodule

// File: rtl/tce_notify.sv
module tce_notify #(
    parameter int AW         = 32,
    parameter int EW         = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [EW-1:0] wr_data,
    output logic          upd_valid,
    output logic [AW-1:0] upd_iova,
    output logic [EW-1:0] upd_page,
    output logic [EW-1:0] upd_mask,
    output logic [1:0]    upd_perm
);
    localparam logic [EW-1:0] OFS_MASK = (EW'(1) << PAGE_SHIFT) - EW'(1);
    localparam logic [AW-1:0] AOFS_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_iova  <= '0;
            upd_page  <= '0;
            upd_perm  <= '0;
        end else begin
            upd_valid <= wr_stb;
            if (wr_stb) begin
                upd_iova <= wr_addr & ~AOFS_MASK;
                upd_page <= wr_data & ~OFS_MASK;
                upd_perm <= wr_data[1:0];
            end
        end
    end

    assign upd_mask = OFS_MASK;
endmodule

// File: rtl/tce_cmd_fsm.sv
module tce_cmd_fsm
    import tce_cmd_pkg::*;
#(
    parameter int AW          = 32,
    parameter int EW          = 64,
    parameter int MAW         = 32,
    parameter int CNT_W       = 16,
    parameter int DEPTH       = 64,
    parameter int PAGE_SHIFT  = 12,
    parameter int MAX_LIST    = 512,
    parameter int LIST_ALIGN  = 12,
    localparam int IDX_W      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [EW-1:0]    cmd_val,
    input  logic [CNT_W-1:0] cmd_cnt,
    output logic             busy,
    output logic             done,
    output logic             done_err,
    output logic [EW-1:0]    done_data,
    output logic [AW-1:0]    chk_addr,
    input  logic [IDX_W-1:0] chk_idx,
    input  logic             chk_ok,
    output logic             tbl_we,
    output logic             tbl_re,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [EW-1:0]    tbl_wdata,
    input  logic [EW-1:0]    tbl_rdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [MAW-1:0]   mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [EW-1:0]    mem_rsp_data
);
    localparam logic [AW-1:0]  PAGE_BYTES = AW'(1) << PAGE_SHIFT;
    localparam logic [MAW-1:0] WORD_CLR   = ~MAW'(3);

    eng_state_t state, nxt;

    logic [2:0]       op_q;
    logic [AW-1:0]    cur_addr;
    logic [EW-1:0]    wdat_q;
    logic [MAW-1:0]   list_base_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] lidx_q;
    logic             err_q;
    logic [EW-1:0]    rdat_q;

    logic             accept;
    logic [AW-1:0]    cmd_aligned;
    logic             fill_bad;
    logic             list_bad;
    logic             op_bad;
    logic             cnt_zero;
    logic             reject;

    // argument screening on the incoming command
    always_comb begin
        accept      = cmd_valid && (state == ST_IDLE);
        cmd_aligned = cmd_addr & ~(PAGE_BYTES - AW'(1));
        cnt_zero    = (cmd_cnt == '0);
        fill_bad    = (32'(cmd_cnt) > 32'(DEPTH));
        list_bad    = (32'(cmd_cnt) > 32'(MAX_LIST)) ||
                      (cmd_val[LIST_ALIGN-1:0] != '0);
        op_bad      = (cmd_op > OP_LIST);
        reject      = op_bad ||
                      ((cmd_op == OP_FILL) && fill_bad) ||
                      ((cmd_op == OP_LIST) && list_bad);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (reject) begin
                        nxt = ST_DONE;
                    end else begin
                        unique case (cmd_op)
                            OP_STORE: nxt = ST_WRITE;
                            OP_FETCH: nxt = ST_READ_ISSUE;
                            OP_FILL:  nxt = cnt_zero ? ST_DONE : ST_WRITE;
                            OP_LIST:  nxt = cnt_zero ? ST_DONE : ST_FETCH_REQ;
                            default:  nxt = ST_DONE;
                        endcase
                    end
                end
            end
            ST_WRITE: begin
                if (!chk_ok || (left_q == CNT_W'(1))) nxt = ST_DONE;
                else if (op_q == OP_LIST)             nxt = ST_FETCH_REQ;
                else                                  nxt = ST_WRITE;
            end
            ST_FETCH_REQ:  if (mem_req_ready) nxt = ST_FETCH_WAIT;
            ST_FETCH_WAIT: if (mem_rsp_valid) nxt = ST_WRITE;
            ST_READ_ISSUE: nxt = chk_ok ? ST_READ_WAIT : ST_DONE;
            ST_READ_WAIT:  nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_DONE);
        done_err      = err_q;
        done_data     = rdat_q;
        chk_addr      = cur_addr;
        tbl_we        = (state == ST_WRITE) && chk_ok;
        tbl_re        = (state == ST_READ_ISSUE) && chk_ok;
        tbl_idx       = chk_idx;
        tbl_wdata     = wdat_q;
        mem_req_valid = (state == ST_FETCH_REQ);
        mem_req_addr  = list_base_q + (MAW'(lidx_q) << 3);
    end

    // command datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= '0;
            cur_addr    <= '0;
            wdat_q      <= '0;
            list_base_q <= '0;
            left_q      <= '0;
            lidx_q      <= '0;
            err_q       <= 1'b0;
            rdat_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q        <= cmd_op;
                        cur_addr    <= cmd_aligned;
                        wdat_q      <= cmd_val;
                        list_base_q <= cmd_val[MAW-1:0] & WORD_CLR;
                        left_q      <= (cmd_op == OP_STORE) ? CNT_W'(1) : cmd_cnt;
                        lidx_q      <= '0;
                        err_q       <= reject;
                        rdat_q      <= '0;
                    end
                end
                ST_WRITE: begin
                    if (!chk_ok) begin
                        err_q <= 1'b1;
                    end else begin
                        cur_addr <= cur_addr + PAGE_BYTES;
                        left_q   <= left_q - CNT_W'(1);
                        lidx_q   <= lidx_q + CNT_W'(1);
                    end
                end
                ST_FETCH_WAIT: if (mem_rsp_valid) wdat_q <= mem_rsp_data;
                ST_READ_ISSUE: if (!chk_ok) err_q <= 1'b1;
                ST_READ_WAIT:  rdat_q <= tbl_rdata;
                default: ;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R6
    AST_REQ_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R6
    AST_LIST_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (32'(lidx_q) < 32'(MAX_LIST))); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy); // R10
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (cmd_op == OP_FILL) && (cmd_cnt == '0) |=> done && !done_err); // R11
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (cmd_op > OP_LIST) |=> done && done_err); // R9
endmodule

// File: rtl/tce_update_engine.sv
module tce_update_engine #(
    parameter int            AW         = 32,
    parameter int            EW         = 64,
    parameter int            MAW        = 32,
    parameter int            CNT_W      = 16,
    parameter int            DEPTH      = 64,
    parameter int            PAGE_SHIFT = 12,
    parameter logic [AW-1:0] BASE       = 32'h0010_0000,
    parameter int            MAX_LIST   = 512,
    parameter int            LIST_ALIGN = 12,
    localparam int           IDX_W      = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [EW-1:0]    cmd_val,
    input  logic [CNT_W-1:0] cmd_cnt,
    output logic             busy,
    output logic             done,
    output logic             done_err,
    output logic [EW-1:0]    done_data,
    output logic             tbl_we,
    output logic             tbl_re,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [EW-1:0]    tbl_wdata,
    input  logic [EW-1:0]    tbl_rdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [MAW-1:0]   mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [EW-1:0]    mem_rsp_data,
    output logic             upd_valid,
    output logic [AW-1:0]    upd_iova,
    output logic [EW-1:0]    upd_page,
    output logic [EW-1:0]    upd_mask,
    output logic [1:0]       upd_perm
);
    logic [AW-1:0]    chk_addr;
    logic [IDX_W-1:0] chk_idx;
    logic             chk_ok;

    tce_idx_check #(
        .AW(AW), .DEPTH(DEPTH), .PAGE_SHIFT(PAGE_SHIFT), .BASE(BASE)
    ) u_chk (
        .addr(chk_addr), .idx(chk_idx), .in_range(chk_ok)
    );

    tce_cmd_fsm #(
        .AW(AW), .EW(EW), .MAW(MAW), .CNT_W(CNT_W), .DEPTH(DEPTH),
        .PAGE_SHIFT(PAGE_SHIFT), .MAX_LIST(MAX_LIST), .LIST_ALIGN(LIST_ALIGN)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_val(cmd_val), .cmd_cnt(cmd_cnt),
        .busy(busy), .done(done), .done_err(done_err), .done_data(done_data),
        .chk_addr(chk_addr), .chk_idx(chk_idx), .chk_ok(chk_ok),
        .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    tce_notify #(
        .AW(AW), .EW(EW), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_ntf (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(tbl_we), .wr_addr(chk_addr), .wr_data(tbl_wdata),
        .upd_valid(upd_valid), .upd_iova(upd_iova), .upd_page(upd_page),
        .upd_mask(upd_mask), .upd_perm(upd_perm)
    );

    AST_NOTIFY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |=> upd_valid && (upd_perm == $past(tbl_wdata[1:0]))); // R8
    AST_NOTIFY_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_we |=> !upd_valid); // R8
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tbl_we && !tbl_re && !mem_req_valid); // R10
endmodule

// File: tb/sim_tce_update_engine.sv
`timescale 1ns/1ps
module sim_tce_update_engine;
    localparam int          DEPTH = 64;
    localparam logic [31:0] BASE  = 32'h0010_0000;
    localparam logic [31:0] PG    = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [63:0] cmd_val = '0;
    logic [15:0] cmd_cnt = '0;
    logic        busy, done, done_err;
    logic [63:0] done_data;
    logic        tbl_we, tbl_re;
    logic [5:0]  tbl_idx;
    logic [63:0] tbl_wdata;
    logic [63:0] tbl_rdata = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        upd_valid;
    logic [31:0] upd_iova;
    logic [63:0] upd_page, upd_mask;
    logic [1:0]  upd_perm;

    int nvec = 0;
    int nfail = 0;
    int wr_cnt = 0;
    int cyc = 0;

    logic [63:0] tab    [DEPTH];
    logic [63:0] shadow [DEPTH];

    tce_update_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_val(cmd_val), .cmd_cnt(cmd_cnt),
        .busy(busy), .done(done), .done_err(done_err), .done_data(done_data),
        .tbl_we(tbl_we), .tbl_re(tbl_re), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .upd_valid(upd_valid),
        .upd_iova(upd_iova), .upd_page(upd_page), .upd_mask(upd_mask),
        .upd_perm(upd_perm)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] listword(input logic [31:0] a);
        return {a ^ 32'h5A5A_0000, (~a) ^ 32'h0000_0F0F};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    // table RAM and list memory models
    always @(posedge clk) begin
        if (tbl_we) begin
            tab[tbl_idx] <= tbl_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (tbl_re) tbl_rdata <= tab[tbl_idx];
        mem_rsp_valid <= rst_n && mem_req_valid && mem_req_ready;
        mem_rsp_data  <= listword(mem_req_addr);
    end

    always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;

    // update-strobe monitor (R8)
    logic        pend = 1'b0;
    logic [5:0]  pend_idx;
    logic [63:0] pend_dat;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                chk("R8 upd_valid", 64'(upd_valid), 64'd1);
                chk("R8 upd_iova", 64'(upd_iova), 64'(BASE + (32'(pend_idx) << 12)));
                chk("R8 upd_page", upd_page, pend_dat & ~64'hFFF);
                chk("R8 upd_mask", upd_mask, 64'hFFF);
                chk("R8 upd_perm", 64'(upd_perm), 64'(pend_dat[1:0]));
            end else if (upd_valid) begin
                chk("R8 stray upd_valid", 64'(upd_valid), 64'd0);
            end
            pend     = tbl_we;
            pend_idx = tbl_idx;
            pend_dat = tbl_wdata;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL R10 watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    // reference model of the command set
    task automatic model(input logic [2:0] op, input logic [31:0] addr,
                         input logic [63:0] val, input logic [15:0] cnt,
                         output logic e, output logic [63:0] d, output int nw);
        logic [31:0] al;
        logic [31:0] ix;
        al = addr & ~32'hFFF;
        e = 1'b0; d = '0; nw = 0;
        case (op)
            3'd0: begin
                ix = (al - BASE) >> 12;
                if (ix < DEPTH) begin shadow[ix] = val; nw = 1; end
                else e = 1'b1;
            end
            3'd1: begin
                ix = (al - BASE) >> 12;
                if (ix < DEPTH) d = shadow[ix];
                else e = 1'b1;
            end
            3'd2: begin
                if (32'(cnt) > DEPTH) e = 1'b1;
                else for (int k = 0; k < int'(cnt); k++) begin
                    ix = ((al + 32'(k) * PG) - BASE) >> 12;
                    if (ix >= DEPTH) begin e = 1'b1; break; end
                    shadow[ix] = val; nw++;
                end
            end
            3'd3: begin
                if (32'(cnt) > 512 || val[11:0] != 12'h0) e = 1'b1;
                else for (int k = 0; k < int'(cnt); k++) begin
                    ix = ((al + 32'(k) * PG) - BASE) >> 12;
                    if (ix >= DEPTH) begin e = 1'b1; break; end
                    shadow[ix] = listword((val[31:0] & ~32'h3) + 32'(k) * 8);
                    nw++;
                end
            end
            default: e = 1'b1;
        endcase
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [31:0] addr,
                           input logic [63:0] val, input logic [15:0] cnt);
        logic        ee;
        logic [63:0] ed;
        int          enw;
        int          w0;
        int          guard;
        string       tag;
        case (op)
            3'd0: tag = "R1";
            3'd1: tag = "R3";
            3'd2: tag = "R4";
            3'd3: tag = "R6";
            default: tag = "R9";
        endcase
        model(op, addr, val, cnt, ee, ed, enw);
        @(negedge clk);
        w0 = wr_cnt;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_val = val; cmd_cnt = cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({"R10 busy after accept ", tag}, 64'(busy), 64'd1);
        guard = 0;
        while (!done && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " status"}, 64'(done_err), 64'(ee));
        chk({tag, " data"}, done_data, ed);
        @(negedge clk);
        chk({"R10 busy after done ", tag}, 64'(busy), 64'd0);
        chk({"R7 write count ", tag}, 64'(wr_cnt - w0), 64'(enw));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) begin tab[i] = '0; shadow[i] = '0; end
        repeat (4) @(negedge clk);
        // R12 reset state
        chk("R12 busy", 64'(busy), 64'd0);
        chk("R12 done", 64'(done), 64'd0);
        chk("R12 tbl_we", 64'(tbl_we), 64'd0);
        chk("R12 tbl_re", 64'(tbl_re), 64'd0);
        chk("R12 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R12 upd_valid", 64'(upd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: last valid index with offset bits, then past the end and below base
        run_cmd(3'd0, BASE + 63 * PG + 32'h0ABC, 64'h1234_5678_9ABC_DEF3, 0);
        run_cmd(3'd1, BASE + 63 * PG + 32'h0001, 0, 0);
        run_cmd(3'd0, BASE + 64 * PG, 64'hDEAD, 0);
        run_cmd(3'd0, BASE - 32'h10, 64'hBEEF, 0);
        run_cmd(3'd1, BASE + 100 * PG, 0, 0);            // R3 out of range
        // R4 fill: exact depth, one over, run off the end
        run_cmd(3'd2, BASE, 64'hAAAA_0000_0000_1002, 16'd64);
        run_cmd(3'd2, BASE, 64'h1, 16'd65);
        run_cmd(3'd2, BASE + 60 * PG + 32'h7, 64'h5555_0001, 16'd8);  // R7
        // R11 zero counts
        run_cmd(3'd2, BASE, 64'h77, 16'd0);
        run_cmd(3'd3, BASE, 64'h0000_0000_0004_0000, 16'd0);
        // R5 list argument errors
        run_cmd(3'd3, BASE, 64'h0000_0000_0004_0000, 16'd513);
        run_cmd(3'd3, BASE, 64'h0000_0000_0004_0008, 16'd2);
        run_cmd(3'd3, BASE, 64'h0000_0000_0004_0001, 16'd2);
        // R6 list, maximum length, stops at the table end (R7)
        run_cmd(3'd3, BASE + 2 * PG, 64'h0000_0000_0008_0000, 16'd5);
        run_cmd(3'd3, BASE, 64'h0000_0000_0010_0000, 16'd512);
        // R9 unknown opcodes
        for (int o = 4; o < 8; o++) run_cmd(3'(o), BASE, 64'h99, 16'd1);

        // constrained random mix
        for (int n = 0; n < 250; n++) begin
            logic [3:0]  r;
            logic [2:0]  op;
            logic [31:0] addr;
            logic [63:0] val;
            logic [15:0] cnt;
            r    = 4'($urandom % 16);
            addr = BASE + ($urandom % 72) * PG + ($urandom % 4096);
            if ($urandom % 16 == 0) addr = $urandom;
            val  = {$urandom, $urandom};
            cnt  = 16'($urandom % 70);
            if (r < 4)       op = 3'd0;
            else if (r < 7)  op = 3'd1;
            else if (r < 10) op = 3'd2;
            else if (r < 14) begin
                op  = 3'd3;
                cnt = 16'($urandom % 24);
                val = {32'h0, $urandom & 32'hFFFF_F000};
                if ($urandom % 8 == 0)  val = val + 64'(1 + $urandom % 4095);
                if ($urandom % 16 == 0) cnt = 16'(513 + $urandom % 100);
            end else op = 3'(4 + $urandom % 4);
            run_cmd(op, addr, val, cnt);
        end

        // R3 sweep: every entry read back through the command port
        for (int i = 0; i < DEPTH; i++) run_cmd(3'd1, BASE + 32'(i) * PG, 0, 0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule